// File: doc/BRIEF.md
# Two-Bank DMA Channel Start and Chunk Controller

This block holds the control state of a DMA engine whose channels are split over two banks. Software programs each channel through a small register window (memory address, block geometry, control word, tag address) and sets a per-channel enable bit in the priority register of the channel's bank. On a control-register write the block decides whether the channel may start. It checks the requested direction against what the channel can do, loads a byte count derived from the block geometry, and then serves the running channels one chunk at a time over a request/acknowledge handshake to the peripherals.

The peripheral that owns a chunk reports how many bytes it moved, or that it failed. The block then advances the channel's address and remaining count. When a channel has nothing left, or has failed, the block clears its active bit and emits a one-cycle interrupt on the output of that channel's bank, tagged with the channel's index inside the bank. The data path itself is not part of this block.

Top module: `dmac_start_ctrl`

## Requirements
- R1: Each channel has a 16-byte window at bank base + 16 × local index, with the address register at offset 0x0, the block register at 0x4, the control register at 0x8 and the tag register at 0xC. Bank 1 holds channels 0 to 6 and starts at 0x080. Bank 2 holds channels 7 and up, uses local index (channel − 7) and starts at 0x100. The bank priority registers sit at 0x0F0 and 0x170. All these registers read back what was written, and all of them read 0 after reset.
- R2: A start is evaluated in the cycle after a control-register write. It needs control bit 24 (active) set and priority bit (4 × local index + 3) of the channel's bank set. Without the priority bit, nothing is requested and the control word keeps bit 24.
- R3: On start the remaining count is 4 × block[15:0] × block[31:16] bytes. That value is shown on `dev_left` with the channel's first request.
- R4: Control bit 0 selects the direction: 1 moves data toward the peripheral and 0 moves it from the peripheral. By default channel 1 cannot move data toward the peripheral and channel 3 cannot move data from it. A start in an unsupported direction clears bit 24 and raises no request and no interrupt.
- R5: A disabled channel (channel 2 by default) ignores starts. Its bit 24 stays as written and it raises no request.
- R6: On each acknowledge without error, the channel address advances by `dev_bytes`, the remaining count drops by the same amount, and the next request shows the new address.
- R7: A running channel whose remaining count is zero or negative finishes. This covers a zero-length block and a final chunk that overshoots. On finishing, bit 24 is cleared and one interrupt pulse follows.
- R8: An acknowledge with `dev_err` set finishes the channel at once, without advancing its address. Bit 24 is cleared and the interrupt pulse appears in the next cycle.
- R9: Finishing channels below 7 pulse `irq_lo_pulse` with `irq_lo_idx` = channel. Finishing channels 7 and up pulse `irq_hi_pulse` with `irq_hi_idx` = channel − 7. The two outputs never pulse in the same cycle.
- R10: At most one request is outstanding, and it is held until it is acknowledged. Whenever the handshake is free, the lowest-numbered running channel is served next, one chunk at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register byte address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for `bus_addr` (combinational) |
| dev_req | output | NUM_CH | One-hot chunk request to a channel's peripheral |
| dev_ack | input | NUM_CH | Chunk acknowledge per channel |
| dev_bytes | input | 16 | Bytes processed in the acknowledged chunk |
| dev_err | input | 1 | Acknowledged chunk failed |
| dev_addr | output | 32 | Current address of the requesting channel |
| dev_left | output | 34 | Remaining bytes of the requesting channel |
| irq_lo_pulse | output | 1 | Bank 1 finish interrupt pulse |
| irq_lo_idx | output | 3 | Bank 1 local channel index |
| irq_hi_pulse | output | 1 | Bank 2 finish interrupt pulse |
| irq_hi_idx | output | 3 | Bank 2 local channel index (channel − 7) |

## Verification
The bench goes after the gating corners. It writes the active bit with the bank enable clear, which a design that ignored the priority register would start anyway. It asks for an unsupported direction, which a design without the capability check would transfer or leave marked active. It starts a disabled channel, which a design could wrongly clear. It also covers a zero-length block, a final chunk that overshoots the count, and an error acknowledge. A wrong zero-or-below test would hang or over-request on the first two, and a design that advanced the address on error would leave the wrong address behind. Interrupts from bank-2 channels must carry the rebased index. Starting three channels while one request is held shows whether the design keeps a single outstanding request and resumes in ascending order.

// File: rtl/dmac_pkg.sv
package dmac_pkg;

    localparam int REG_W      = 32;
    localparam int ACT_BIT    = 24;
    localparam int DIR_BIT    = 0;
    localparam int BANK_SPLIT = 7;
    localparam int BYTES_W    = 16;
    localparam int LEFT_W     = 34;
    localparam int REM_W      = LEFT_W + 1;
    localparam int IDX_W      = 3;

    typedef enum logic [1:0] {
        FLD_ADDR  = 2'd0,
        FLD_BLOCK = 2'd1,
        FLD_CTRL  = 2'd2,
        FLD_TAG   = 2'd3
    } fld_e;

    typedef struct packed {
        logic [REG_W-1:0] addr;
        logic [REG_W-1:0] block;
        logic [REG_W-1:0] ctrl;
        logic [REG_W-1:0] tag;
    } chan_regs_t;

    typedef enum logic {
        SCH_IDLE = 1'b0,
        SCH_WAIT = 1'b1
    } sch_e;

    // bytes = 4 * size * count
    function automatic logic [LEFT_W-1:0] xfer_len(input logic [REG_W-1:0] block);
        logic [31:0] prod;
        prod = 32'(block[15:0]) * 32'(block[31:16]);
        return {prod, 2'b00};
    endfunction

    function automatic int local_idx(input int ch);
        return (ch >= BANK_SPLIT) ? ch - BANK_SPLIT : ch;
    endfunction

    function automatic int prio_pos(input int ch);
        return 4 * local_idx(ch) + 3;
    endfunction

endpackage

// File: rtl/dmac_chan.sv
module dmac_chan
    import dmac_pkg::*;
#(
    parameter bit CAP_ON       = 1'b1,
    parameter bit CAP_TO_DEV   = 1'b1,
    parameter bit CAP_FROM_DEV = 1'b1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  fld_e               wr_fld,
    input  logic [REG_W-1:0]   wr_data,
    input  logic               prio_ok,
    input  logic               step,
    input  logic [BYTES_W-1:0] step_bytes,
    input  logic               finish,
    output chan_regs_t         regs,
    output logic               busy,
    output logic [LEFT_W-1:0]  left,
    output logic               done
);

    logic                    pending;
    logic signed [REM_W-1:0] rem;
    logic                    dir_ok;
    logic                    start_ok;

    always_comb begin
        dir_ok   = regs.ctrl[DIR_BIT] ? CAP_TO_DEV : CAP_FROM_DEV;
        start_ok = CAP_ON && pending && !busy && regs.ctrl[ACT_BIT] && prio_ok;
        done     = busy && (rem[REM_W-1] || (rem == '0));
        left     = rem[LEFT_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            regs    <= '0;
            busy    <= 1'b0;
            rem     <= '0;
            pending <= 1'b0;
        end else begin
            pending <= wr_en && (wr_fld == FLD_CTRL);

            if (start_ok) begin
                if (dir_ok) begin
                    busy <= 1'b1;
                    rem  <= $signed({1'b0, xfer_len(regs.block)});
                end else begin
                    regs.ctrl[ACT_BIT] <= 1'b0;
                end
            end

            if (step) begin
                regs.addr <= regs.addr + REG_W'(step_bytes);
                rem       <= rem - $signed({{(REM_W-BYTES_W){1'b0}}, step_bytes});
            end

            if (finish) begin
                busy               <= 1'b0;
                regs.ctrl[ACT_BIT] <= 1'b0;
            end

            if (wr_en) begin
                case (wr_fld)
                    FLD_ADDR:  regs.addr  <= wr_data;
                    FLD_BLOCK: regs.block <= wr_data;
                    FLD_CTRL:  regs.ctrl  <= wr_data;
                    FLD_TAG:   regs.tag   <= wr_data;
                    default:   ;
                endcase
            end
        end
    end

endmodule

// File: rtl/dmac_sched.sv
module dmac_sched
    import dmac_pkg::*;
#(
    parameter  int NUM_CH = 10,
    localparam int CH_W   = $clog2(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_CH-1:0] busy,
    input  logic [NUM_CH-1:0] done,
    input  logic [NUM_CH-1:0] dev_ack,
    input  logic              dev_err,
    output logic [NUM_CH-1:0] dev_req,
    output logic [NUM_CH-1:0] step,
    output logic [NUM_CH-1:0] finish,
    output logic [CH_W-1:0]   cur
);

    sch_e            state;
    logic            found;
    logic [CH_W-1:0] pick;

    // lowest-numbered running channel wins
    always_comb begin
        found = 1'b0;
        pick  = '0;
        for (int i = NUM_CH - 1; i >= 0; i--) begin
            if (busy[i]) begin
                found = 1'b1;
                pick  = CH_W'(i);
            end
        end
    end

    always_comb begin
        dev_req = '0;
        step    = '0;
        finish  = '0;
        if (state == SCH_IDLE) begin
            if (found && done[pick]) finish[pick] = 1'b1;
        end else begin
            dev_req[cur] = 1'b1;
            if (dev_ack[cur]) begin
                if (dev_err) finish[cur] = 1'b1;
                else         step[cur]   = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SCH_IDLE;
            cur   <= '0;
        end else begin
            case (state)
                SCH_IDLE: begin
                    if (found && !done[pick]) begin
                        state <= SCH_WAIT;
                        cur   <= pick;
                    end
                end
                SCH_WAIT: begin
                    if (dev_ack[cur]) state <= SCH_IDLE;
                end
                default: state <= SCH_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/dmac_irq_route.sv
module dmac_irq_route
    import dmac_pkg::*;
#(
    parameter int NUM_CH = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_CH-1:0] finish,
    output logic              lo_pulse,
    output logic [IDX_W-1:0]  lo_idx,
    output logic              hi_pulse,
    output logic [IDX_W-1:0]  hi_idx
);

    logic             n_lo;
    logic             n_hi;
    logic [IDX_W-1:0] n_lo_idx;
    logic [IDX_W-1:0] n_hi_idx;

    always_comb begin
        n_lo     = 1'b0;
        n_hi     = 1'b0;
        n_lo_idx = '0;
        n_hi_idx = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (finish[i]) begin
                if (i < BANK_SPLIT) begin
                    n_lo     = 1'b1;
                    n_lo_idx = IDX_W'(i);
                end else begin
                    n_hi     = 1'b1;
                    n_hi_idx = IDX_W'(i - BANK_SPLIT);
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lo_pulse <= 1'b0;
            hi_pulse <= 1'b0;
            lo_idx   <= '0;
            hi_idx   <= '0;
        end else begin
            lo_pulse <= n_lo;
            hi_pulse <= n_hi;
            lo_idx   <= n_lo_idx;
            hi_idx   <= n_hi_idx;
        end
    end

endmodule

// File: rtl/dmac_regdec.sv
module dmac_regdec
    import dmac_pkg::*;
#(
    parameter int                NUM_CH    = 10,
    parameter int                ADDR_W    = 10,
    parameter logic [ADDR_W-1:0] LO_BASE   = 10'h080,
    parameter logic [ADDR_W-1:0] HI_BASE   = 10'h100,
    parameter logic [ADDR_W-1:0] LO_PRIO_A = 10'h0F0,
    parameter logic [ADDR_W-1:0] HI_PRIO_A = 10'h170
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     bus_wr,
    input  logic [ADDR_W-1:0]        bus_addr,
    input  logic [REG_W-1:0]         bus_wdata,
    input  chan_regs_t [NUM_CH-1:0]  regs,
    output logic [NUM_CH-1:0]        ch_wr,
    output fld_e                     wr_fld,
    output logic [REG_W-1:0]         prio_lo,
    output logic [REG_W-1:0]         prio_hi,
    output logic [REG_W-1:0]         bus_rdata
);

    logic [NUM_CH-1:0] win_hit;
    logic              lo_p_hit;
    logic              hi_p_hit;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_win
        localparam logic [ADDR_W-1:0] WBASE = (c < BANK_SPLIT)
            ? LO_BASE + ADDR_W'(16 * c)
            : HI_BASE + ADDR_W'(16 * (c - BANK_SPLIT));
        assign win_hit[c] = (bus_addr[ADDR_W-1:4] == WBASE[ADDR_W-1:4])
                          && (bus_addr[1:0] == 2'b00);
    end

    always_comb begin
        wr_fld   = fld_e'(bus_addr[3:2]);
        ch_wr    = bus_wr ? win_hit : '0;
        lo_p_hit = (bus_addr == LO_PRIO_A);
        hi_p_hit = (bus_addr == HI_PRIO_A);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prio_lo <= '0;
            prio_hi <= '0;
        end else if (bus_wr) begin
            if (lo_p_hit) prio_lo <= bus_wdata;
            if (hi_p_hit) prio_hi <= bus_wdata;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (lo_p_hit) bus_rdata = prio_lo;
        if (hi_p_hit) bus_rdata = prio_hi;
        for (int i = 0; i < NUM_CH; i++) begin
            if (win_hit[i]) begin
                case (wr_fld)
                    FLD_ADDR:  bus_rdata = regs[i].addr;
                    FLD_BLOCK: bus_rdata = regs[i].block;
                    FLD_CTRL:  bus_rdata = regs[i].ctrl;
                    FLD_TAG:   bus_rdata = regs[i].tag;
                    default:   ;
                endcase
            end
        end
    end

endmodule

// File: rtl/dmac_start_ctrl.sv
module dmac_start_ctrl
    import dmac_pkg::*;
#(
    parameter  int                NUM_CH       = 10,
    parameter  int                ADDR_W       = 10,
    parameter  logic [ADDR_W-1:0] LO_BASE      = 10'h080,
    parameter  logic [ADDR_W-1:0] HI_BASE      = 10'h100,
    parameter  logic [ADDR_W-1:0] LO_PRIO_A    = 10'h0F0,
    parameter  logic [ADDR_W-1:0] HI_PRIO_A    = 10'h170,
    parameter  logic [NUM_CH-1:0] CH_ON        = 10'b11_1111_1011,
    parameter  logic [NUM_CH-1:0] CAN_TO_DEV   = 10'b11_1111_1101,
    parameter  logic [NUM_CH-1:0] CAN_FROM_DEV = 10'b11_1111_0111,
    localparam int                CH_W         = $clog2(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic [NUM_CH-1:0] dev_req,
    input  logic [NUM_CH-1:0] dev_ack,
    input  logic [15:0]       dev_bytes,
    input  logic              dev_err,
    output logic [31:0]       dev_addr,
    output logic [33:0]       dev_left,
    output logic              irq_lo_pulse,
    output logic [2:0]        irq_lo_idx,
    output logic              irq_hi_pulse,
    output logic [2:0]        irq_hi_idx
);

    chan_regs_t [NUM_CH-1:0] regs_arr;
    logic [LEFT_W-1:0]       left_arr [NUM_CH];
    logic [NUM_CH-1:0]       ch_wr;
    fld_e                    wr_fld;
    logic [REG_W-1:0]        prio_lo;
    logic [REG_W-1:0]        prio_hi;
    logic [NUM_CH-1:0]       prio_vec;
    logic [NUM_CH-1:0]       busy;
    logic [NUM_CH-1:0]       done;
    logic [NUM_CH-1:0]       step;
    logic [NUM_CH-1:0]       finish;
    logic [CH_W-1:0]         cur;

    dmac_regdec #(
        .NUM_CH   (NUM_CH),
        .ADDR_W   (ADDR_W),
        .LO_BASE  (LO_BASE),
        .HI_BASE  (HI_BASE),
        .LO_PRIO_A(LO_PRIO_A),
        .HI_PRIO_A(HI_PRIO_A)
    ) u_regdec (
        .clk      (clk),
        .rst      (rst),
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .regs     (regs_arr),
        .ch_wr    (ch_wr),
        .wr_fld   (wr_fld),
        .prio_lo  (prio_lo),
        .prio_hi  (prio_hi),
        .bus_rdata(bus_rdata)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
        if (c < BANK_SPLIT) begin : g_lo
            assign prio_vec[c] = prio_lo[prio_pos(c)];
        end else begin : g_hi
            assign prio_vec[c] = prio_hi[prio_pos(c)];
        end

        dmac_chan #(
            .CAP_ON      (CH_ON[c]),
            .CAP_TO_DEV  (CAN_TO_DEV[c]),
            .CAP_FROM_DEV(CAN_FROM_DEV[c])
        ) u_chan (
            .clk       (clk),
            .rst       (rst),
            .wr_en     (ch_wr[c]),
            .wr_fld    (wr_fld),
            .wr_data   (bus_wdata),
            .prio_ok   (prio_vec[c]),
            .step      (step[c]),
            .step_bytes(dev_bytes),
            .finish    (finish[c]),
            .regs      (regs_arr[c]),
            .busy      (busy[c]),
            .left      (left_arr[c]),
            .done      (done[c])
        );
    end

    dmac_sched #(.NUM_CH(NUM_CH)) u_sched (
        .clk    (clk),
        .rst    (rst),
        .busy   (busy),
        .done   (done),
        .dev_ack(dev_ack),
        .dev_err(dev_err),
        .dev_req(dev_req),
        .step   (step),
        .finish (finish),
        .cur    (cur)
    );

    dmac_irq_route #(.NUM_CH(NUM_CH)) u_irq (
        .clk     (clk),
        .rst     (rst),
        .finish  (finish),
        .lo_pulse(irq_lo_pulse),
        .lo_idx  (irq_lo_idx),
        .hi_pulse(irq_hi_pulse),
        .hi_idx  (irq_hi_idx)
    );

    always_comb begin
        dev_addr = regs_arr[cur].addr;
        dev_left = left_arr[cur];
    end

endmodule

// File: rtl/dmac_start_ctrl_chk.sv
module dmac_start_ctrl_chk #(
    parameter int NUM_CH = 10
) (
    input logic              clk,
    input logic              rst,
    input logic [NUM_CH-1:0] dev_req,
    input logic [NUM_CH-1:0] dev_ack,
    input logic              dev_err,
    input logic              irq_lo_pulse,
    input logic [2:0]        irq_lo_idx,
    input logic              irq_hi_pulse,
    input logic [2:0]        irq_hi_idx
);

    // R10: a single outstanding request
    p_one_request_r10: assert property (@(posedge clk) disable iff (rst)
        $onehot0(dev_req));

    // R10: request held until acknowledged
    p_hold_request_r10: assert property (@(posedge clk) disable iff (rst)
        (dev_req != '0 && (dev_req & dev_ack) == '0) |=> (dev_req == $past(dev_req)));

    // R8: error acknowledge produces an interrupt in the next cycle
    p_err_irq_r8: assert property (@(posedge clk) disable iff (rst)
        ((dev_req & dev_ack) != '0 && dev_err) |=> (irq_lo_pulse || irq_hi_pulse));

    // R9: one bank at a time
    p_single_bank_r9: assert property (@(posedge clk) disable iff (rst)
        !(irq_lo_pulse && irq_hi_pulse));

    // R9: bank-1 index in range
    p_lo_range_r9: assert property (@(posedge clk) disable iff (rst)
        irq_lo_pulse |-> (int'(irq_lo_idx) < 7));

    // R9: bank-2 index rebased and in range
    p_hi_range_r9: assert property (@(posedge clk) disable iff (rst)
        irq_hi_pulse |-> (int'(irq_hi_idx) < NUM_CH - 7));

endmodule

bind dmac_start_ctrl dmac_start_ctrl_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .dev_req     (dev_req),
    .dev_ack     (dev_ack),
    .dev_err     (dev_err),
    .irq_lo_pulse(irq_lo_pulse),
    .irq_lo_idx  (irq_lo_idx),
    .irq_hi_pulse(irq_hi_pulse),
    .irq_hi_idx  (irq_hi_idx)
);

// File: tb/test_dmac_start_ctrl.sv
module test_dmac_start_ctrl;

    localparam int N = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        bus_wr;
    logic [9:0]  bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic [N-1:0] dev_req;
    logic [N-1:0] dev_ack;
    logic [15:0] dev_bytes;
    logic        dev_err;
    logic [31:0] dev_addr;
    logic [33:0] dev_left;
    logic        irq_lo_pulse;
    logic [2:0]  irq_lo_idx;
    logic        irq_hi_pulse;
    logic [2:0]  irq_hi_idx;

    always #10 clk = ~clk;

    dmac_start_ctrl i_dmac_start_ctrl (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .dev_req(dev_req),
        .dev_ack(dev_ack), .dev_bytes(dev_bytes), .dev_err(dev_err),
        .dev_addr(dev_addr), .dev_left(dev_left), .irq_lo_pulse(irq_lo_pulse),
        .irq_lo_idx(irq_lo_idx), .irq_hi_pulse(irq_hi_pulse), .irq_hi_idx(irq_hi_idx)
    );

    int     n_chk  = 0;
    int     n_fail = 0;
    int     exp_svc[$];
    int     exp_irq[$];
    int     chunk_sz[N];
    bit     err_on[N];
    longint m_addr[N];
    longint m_left[N];
    bit     hold;
    int     p_ch;
    int     p_exp;
    logic [31:0] rd;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [9:0] win(input int ch);
        return (ch < 7) ? 10'(10'h080 + 16 * ch) : 10'(10'h100 + 16 * (ch - 7));
    endfunction

    task automatic bus_write(input logic [9:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [9:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic expect_reg(input logic [9:0] a, input logic [31:0] e, input string req);
        logic [31:0] v;
        bus_read(a, v);
        check(v == e, req, v, e);
    endtask

    task automatic setup_ch(input int ch, input longint addr, input int size, input int count, input int chunk);
        bus_write(win(ch) + 10'h0, 32'(addr));
        bus_write(win(ch) + 10'h4, {16'(count), 16'(size)});
        m_addr[ch]   = addr;
        m_left[ch]   = 4 * longint'(size) * longint'(count);
        chunk_sz[ch] = chunk;
    endtask

    task automatic drain(input string req);
        int t;
        t = 0;
        while ((exp_svc.size() != 0 || exp_irq.size() != 0) && t < 3000) begin
            @(negedge clk);
            t++;
        end
        repeat (4) @(negedge clk);
        check(exp_svc.size() == 0 && exp_irq.size() == 0, req,
              exp_svc.size() + exp_irq.size(), 0);
    endtask

    task automatic got_irq(input int code);
        int e;
        if (exp_irq.size() == 0) begin
            check(1'b0, "R9 unexpected interrupt", code, -1);
        end else begin
            e = exp_irq.pop_front();
            check(code == e, "R9 interrupt route", code, e);
        end
    endtask

    task automatic summary;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    // peripheral model: serves and scores each request
    initial begin
        dev_ack = '0; dev_bytes = '0; dev_err = 1'b0;
        forever begin
            @(negedge clk);
            if (!rst && !hold && dev_req != '0) begin
                p_ch = -1;
                for (int i = 0; i < N; i++) if (dev_req[i]) p_ch = i;
                if (exp_svc.size() == 0) begin
                    check(1'b0, "R10 unexpected request", p_ch, -1);
                end else begin
                    p_exp = exp_svc.pop_front();
                    check(p_ch == p_exp, "R10 service order", p_ch, p_exp);
                end
                check(dev_addr == 32'(m_addr[p_ch]), "R6 chunk address", dev_addr, m_addr[p_ch]);
                check(longint'(dev_left) == m_left[p_ch], "R3 remaining count",
                      longint'(dev_left), m_left[p_ch]);
                dev_ack   = dev_req;
                dev_bytes = 16'(chunk_sz[p_ch]);
                dev_err   = err_on[p_ch];
                if (!err_on[p_ch]) begin
                    m_addr[p_ch] += chunk_sz[p_ch];
                    m_left[p_ch] -= chunk_sz[p_ch];
                end
                @(negedge clk);
                dev_ack = '0;
                dev_err = 1'b0;
            end
        end
    end

    // interrupt monitor
    initial begin
        forever begin
            @(negedge clk);
            if (!rst) begin
                if (irq_lo_pulse) got_irq(int'(irq_lo_idx));
                if (irq_hi_pulse) got_irq(16 + int'(irq_hi_idx));
            end
        end
    end

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        check(1'b0, "WATCHDOG", 0, 1);
        summary();
        $finish;
    end

    initial begin
        rst = 1'b1; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0; hold = 1'b0;
        for (int i = 0; i < N; i++) begin
            chunk_sz[i] = 4; err_on[i] = 1'b0; m_addr[i] = 0; m_left[i] = 0;
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // reset state
        expect_reg(win(0) + 10'h8, 32'h0, "R1 reset control");
        expect_reg(10'h0F0, 32'h0, "R1 reset priority");
        check(dev_req == '0, "R10 reset request", dev_req, 0);

        // R1: windows and read back
        bus_write(win(0) + 10'h0, 32'h0000_1000);
        bus_write(win(0) + 10'h4, 32'h0002_0003);
        bus_write(win(0) + 10'hC, 32'h0000_CAFE);
        bus_write(10'h11C, 32'h0000_ABCD);
        expect_reg(10'h080, 32'h0000_1000, "R1 address field");
        expect_reg(10'h084, 32'h0002_0003, "R1 block field");
        expect_reg(10'h08C, 32'h0000_CAFE, "R1 tag field");
        expect_reg(10'h11C, 32'h0000_ABCD, "R1 bank-2 tag field");

        // R2: active bit without bank enable
        bus_write(win(0) + 10'h8, 32'h0100_0001);
        repeat (6) @(negedge clk);
        check(dev_req == '0, "R2 no start without enable", dev_req, 0);
        expect_reg(win(0) + 10'h8, 32'h0100_0001, "R2 active kept");

        // R2/R3/R6/R7: 24-byte transfer, 8-byte chunks
        m_addr[0] = 32'h1000; m_left[0] = 24; chunk_sz[0] = 8;
        exp_svc.push_back(0); exp_svc.push_back(0); exp_svc.push_back(0);
        exp_irq.push_back(0);
        bus_write(10'h0F0, 32'h0000_0008);
        expect_reg(10'h0F0, 32'h0000_0008, "R1 priority field");
        bus_write(win(0) + 10'h8, 32'h0100_0001);
        drain("R7 transfer completes");
        expect_reg(win(0) + 10'h8, 32'h0000_0001, "R7 active cleared");
        expect_reg(win(0) + 10'h0, 32'h0000_1018, "R6 address advanced");

        // R7: overshoot (20 bytes in 8-byte chunks)
        setup_ch(0, 32'h1018, 5, 1, 8);
        exp_svc.push_back(0); exp_svc.push_back(0); exp_svc.push_back(0);
        exp_irq.push_back(0);
        bus_write(win(0) + 10'h8, 32'h0100_0000);
        drain("R7 overshoot completes");
        expect_reg(win(0) + 10'h0, 32'h0000_1030, "R6 address after overshoot");

        // R4: unsupported directions
        bus_write(10'h0F0, 32'h0088_8888);
        bus_write(win(1) + 10'h4, 32'h0001_0001);
        bus_write(win(1) + 10'h8, 32'h0100_0001);
        repeat (6) @(negedge clk);
        check(dev_req == '0, "R4 ch1 no request", dev_req, 0);
        expect_reg(win(1) + 10'h8, 32'h0000_0001, "R4 ch1 active cleared");
        bus_write(win(3) + 10'h8, 32'h0100_0000);
        repeat (6) @(negedge clk);
        check(dev_req == '0, "R4 ch3 no request", dev_req, 0);
        expect_reg(win(3) + 10'h8, 32'h0000_0000, "R4 ch3 active cleared");
        setup_ch(1, 0, 1, 1, 4);
        exp_svc.push_back(1); exp_irq.push_back(1);
        bus_write(win(1) + 10'h8, 32'h0100_0000);
        drain("R4 supported direction runs");

        // R5: disabled channel
        bus_write(win(2) + 10'h4, 32'h0001_0001);
        bus_write(win(2) + 10'h8, 32'h0100_0000);
        repeat (6) @(negedge clk);
        check(dev_req == '0, "R5 disabled no request", dev_req, 0);
        expect_reg(win(2) + 10'h8, 32'h0100_0000, "R5 active kept");

        // R8: error acknowledge
        setup_ch(4, 32'h2000, 1, 4, 4);
        err_on[4] = 1'b1;
        exp_svc.push_back(4); exp_irq.push_back(4);
        bus_write(win(4) + 10'h8, 32'h0100_0001);
        drain("R8 error finishes");
        err_on[4] = 1'b0;
        expect_reg(win(4) + 10'h0, 32'h0000_2000, "R8 address unchanged");
        expect_reg(win(4) + 10'h8, 32'h0000_0001, "R8 active cleared");

        // R9: bank-2 routing, R7 zero length
        bus_write(10'h170, 32'h0000_0088);
        setup_ch(8, 32'h3000, 2, 1, 8);
        exp_svc.push_back(8); exp_irq.push_back(16 + 1);
        bus_write(win(8) + 10'h8, 32'h0100_0000);
        drain("R9 bank-2 channel 8");
        setup_ch(7, 32'h3800, 0, 0, 4);
        exp_irq.push_back(16 + 0);
        bus_write(win(7) + 10'h8, 32'h0100_0000);
        drain("R7 zero length");
        expect_reg(win(7) + 10'h8, 32'h0000_0000, "R7 zero length cleared");

        // R10: ascending order with a held request
        hold = 1'b1;
        setup_ch(5, 32'h4000, 2, 1, 4);
        setup_ch(4, 32'h2000, 1, 1, 4);
        setup_ch(0, 32'h1030, 1, 1, 4);
        bus_write(win(5) + 10'h8, 32'h0100_0000);
        repeat (4) @(negedge clk);
        check(dev_req == N'(1 << 5), "R10 ch5 requesting", dev_req, 1 << 5);
        bus_write(win(4) + 10'h8, 32'h0100_0000);
        bus_write(win(0) + 10'h8, 32'h0100_0000);
        repeat (4) @(negedge clk);
        check(dev_req == N'(1 << 5), "R10 request held", dev_req, 1 << 5);
        exp_svc.push_back(5); exp_svc.push_back(0);
        exp_svc.push_back(4); exp_svc.push_back(5);
        exp_irq.push_back(0); exp_irq.push_back(4); exp_irq.push_back(5);
        hold = 1'b0;
        drain("R10 ordered drain");

        summary();
        $finish;
    end

endmodule